// File: doc/BRIEF.md
# Interrupt presentation controller

This block presents interrupts to a single processor. It keeps four values: the processor's current priority, a priority for inter-processor interrupts (IPIs), the priority of the interrupt now waiting, and that interrupt's source number. Priorities are 8 bits wide. A lower number is more favored. The value 0xFF stands for "nothing pending" or "masked".

One command can be issued per clock. The commands are:
- accept the waiting interrupt
- change the current priority
- change the IPI priority
- end an interrupt
- offer an external source

The block raises an interrupt request toward the processor. In some cases it must hand a source back to the source controller, either because it cannot present it now or because the source is still asserted. It then emits a one-cycle reject pulse carrying the source number. When the current or IPI priority relaxes after an earlier refusal, it emits a one-cycle resend pulse so that the source controller can offer its sources again.

Top module: `irq_presenter`

## Requirements
- R1: After reset, the current priority is 0, the IPI priority is 0xFF, the pending priority is 0xFF, the pending source is 0 and the need-resend flag is clear. The interrupt request is low, no pulse is emitted, and an accept returns the word 0.
- R2: `irq_req` is high exactly when the pending source is nonzero and the pending priority is numerically lower than the current priority.
- R3: Accept (op 1) places the current priority in bits 31:24 and the pending source in bits 23:0 of `acc_word`, with `acc_valid` high, one cycle after the command. If the source was nonzero, the current priority takes the pending priority, the pending priority becomes 0xFF and the source becomes 0. Otherwise the state is unchanged.
- R4: Set-IPI-priority (op 3, value in bits 7:0) always stores the value. If the value is below the current priority, the IPI source becomes pending at that priority. If the value is also at most the old pending priority, the old source is rejected.
- R5: Set-IPI-priority emits the need-resend flag on `rsnd_valid` and clears the flag when the new value exceeds both the old IPI priority and the current priority.
- R6: Set-current-priority (op 2, value in bits 7:0) with a value equal to the current one changes nothing and emits nothing.
- R7: Set-current-priority with a larger value stores it. The IPI then becomes pending at the IPI priority if the IPI priority is below the new value and at most the pending priority. The need-resend flag is emitted on `rsnd_valid` and cleared.
- R8: Set-current-priority with a smaller value stores it. If the new value is at most the pending priority, the pending source is rejected, the source becomes 0 and the pending priority becomes 0xFF.
- R9: End-of-interrupt (op 4) takes the new current priority from bits 31:24 and always applies the R7 path, even when the value is not larger. The source in bits 23:0 is rejected when it is not the IPI source and `eoi_asserted` is high.
- R10: A reject whose source is 0 or the IPI source (parameter, default 2) never raises `rej_valid`.
- R11: Deliver (op 5) offers the priority in bits 31:24 and the source in bits 23:0.
  - A source of 0 is ignored.
  - If the offered priority is below both the current and the pending priorities, the offer becomes pending and the old source is rejected.
  - Otherwise the offered source is rejected and the need-resend flag is set.
  - A nonzero pending source always has a pending priority other than 0xFF, and a zero source always has 0xFF.
- R12: Reject, resend and accept outputs are single-cycle pulses registered one cycle after the command. Op 0 and ops 6 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| cmd_data | input | 32 | Command operand (priority and/or source) |
| eoi_asserted | input | 1 | End-of-interrupt source still asserted |
| irq_req | output | 1 | Interrupt request to the processor |
| acc_valid | output | 1 | Accept result strobe |
| acc_word | output | 32 | Accept result {current priority, source} |
| rej_valid | output | 1 | Reject pulse |
| rej_src | output | 24 | Rejected source number |
| rsnd_valid | output | 1 | Resend request pulse |

## Verification
The main sequence works through deliveries in three cases:
- an offer that is more favored than the pending one, which tells displacement apart from refusal;
- an offer that is less favored, which must be refused and must set need-resend;
- an offer with source 0, which must be ignored; a later resend check shows that need-resend stayed clear.

Priority changes are tried with values that are equal to, above and below the current priority, and with IPI priorities on both sides of the current and pending priorities. This separates the store-only case, the IPI-pending case and the reject case. End-of-interrupt is issued with an asserted external source, with the IPI source and with a deasserted source, which shows the reject path and its filter.

// File: rtl/irqp_pkg.sv
package irqp_pkg;
   typedef enum logic [2:0] {
      OP_NONE     = 3'd0,
      OP_ACCEPT   = 3'd1,
      OP_SET_CPPR = 3'd2,
      OP_SET_IPI  = 3'd3,
      OP_EOI      = 3'd4,
      OP_DELIVER  = 3'd5
   } irqp_op_e;
endpackage

// File: rtl/irqp_next.sv
module irqp_next
   import irqp_pkg::*;
#(
   parameter int PRIO_W  = 8,
   parameter int SRC_W   = 24,
   parameter int IPI_SRC = 2,
   localparam int WORD_W = PRIO_W + SRC_W
) (
   input  logic              fire,
   input  irqp_op_e          op,
   input  logic [WORD_W-1:0] data,
   input  logic              eoi_asserted,
   input  logic [PRIO_W-1:0] cur_prio,
   input  logic [PRIO_W-1:0] ipi_prio,
   input  logic [PRIO_W-1:0] pend_prio,
   input  logic [SRC_W-1:0]  pend_src,
   input  logic              need_rsnd,
   output logic [PRIO_W-1:0] n_cur_prio,
   output logic [PRIO_W-1:0] n_ipi_prio,
   output logic [PRIO_W-1:0] n_pend_prio,
   output logic [SRC_W-1:0]  n_pend_src,
   output logic              n_need_rsnd,
   output logic              raw_rej,
   output logic [SRC_W-1:0]  raw_rej_src,
   output logic              raw_rsnd,
   output logic              acc_fire
);
   localparam logic [PRIO_W-1:0] NONE_PRIO = '1;
   localparam logic [SRC_W-1:0]  IPI_ID    = SRC_W'(IPI_SRC);

   logic [PRIO_W-1:0] lo_val;   // low-field priority operand
   logic [PRIO_W-1:0] hi_val;   // high-field priority operand
   logic [SRC_W-1:0]  src_val;  // source operand
   logic [PRIO_W-1:0] dn_val;   // priority used by the relaxing path
   logic              dn_ipi;   // IPI becomes pending on relax

   assign lo_val  = data[PRIO_W-1:0];
   assign hi_val  = data[WORD_W-1:SRC_W];
   assign src_val = data[SRC_W-1:0];
   assign dn_val  = (op == OP_EOI) ? hi_val : lo_val;
   assign dn_ipi  = (ipi_prio < dn_val) && (ipi_prio <= pend_prio);

   always_comb begin
      n_cur_prio  = cur_prio;
      n_ipi_prio  = ipi_prio;
      n_pend_prio = pend_prio;
      n_pend_src  = pend_src;
      n_need_rsnd = need_rsnd;
      raw_rej     = 1'b0;
      raw_rej_src = '0;
      raw_rsnd    = 1'b0;
      acc_fire    = 1'b0;
      if (fire) begin
         unique case (op)
            OP_ACCEPT: begin
               acc_fire = 1'b1;
               if (pend_src != '0) begin
                  n_cur_prio  = pend_prio;
                  n_pend_prio = NONE_PRIO;
                  n_pend_src  = '0;
               end
            end
            OP_SET_IPI: begin
               n_ipi_prio = lo_val;
               if (lo_val < cur_prio) begin
                  if (lo_val <= pend_prio) begin
                     raw_rej     = 1'b1;
                     raw_rej_src = pend_src;
                  end
                  n_pend_prio = lo_val;
                  n_pend_src  = IPI_ID;
               end
               if ((lo_val > ipi_prio) && (lo_val > cur_prio)) begin
                  raw_rsnd    = need_rsnd;
                  n_need_rsnd = 1'b0;
               end
            end
            OP_SET_CPPR, OP_EOI: begin
               if ((op == OP_EOI) || (lo_val > cur_prio)) begin
                  n_cur_prio = dn_val;
                  if (dn_ipi) begin
                     n_pend_prio = ipi_prio;
                     n_pend_src  = IPI_ID;
                  end
                  raw_rsnd    = need_rsnd;
                  n_need_rsnd = 1'b0;
                  if ((op == OP_EOI) && (src_val != IPI_ID) && eoi_asserted) begin
                     raw_rej     = 1'b1;
                     raw_rej_src = src_val;
                  end
               end else if (lo_val < cur_prio) begin
                  n_cur_prio = lo_val;
                  if (lo_val <= pend_prio) begin
                     raw_rej     = 1'b1;
                     raw_rej_src = pend_src;
                     n_pend_src  = '0;
                     n_pend_prio = NONE_PRIO;
                  end
               end
            end
            OP_DELIVER: begin
               if (src_val != '0) begin
                  if ((hi_val < cur_prio) && (hi_val < pend_prio)) begin
                     raw_rej     = 1'b1;
                     raw_rej_src = pend_src;
                     n_pend_prio = hi_val;
                     n_pend_src  = src_val;
                  end else begin
                     raw_rej     = 1'b1;
                     raw_rej_src = src_val;
                     n_need_rsnd = 1'b1;
                  end
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/irqp_notify.sv
module irqp_notify #(
   parameter int PRIO_W  = 8,
   parameter int SRC_W   = 24,
   parameter int IPI_SRC = 2,
   localparam int WORD_W = PRIO_W + SRC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              raw_rej,
   input  logic [SRC_W-1:0]  raw_rej_src,
   input  logic              raw_rsnd,
   input  logic              acc_fire,
   input  logic [PRIO_W-1:0] cur_prio,
   input  logic [SRC_W-1:0]  pend_src,
   output logic              rej_valid,
   output logic [SRC_W-1:0]  rej_src,
   output logic              rsnd_valid,
   output logic              acc_valid,
   output logic [WORD_W-1:0] acc_word
);
   localparam logic [SRC_W-1:0] IPI_ID = SRC_W'(IPI_SRC);

   logic rej_pass;
   assign rej_pass = raw_rej && (raw_rej_src != '0) && (raw_rej_src != IPI_ID);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rej_valid  <= 1'b0;
         rej_src    <= '0;
         rsnd_valid <= 1'b0;
         acc_valid  <= 1'b0;
         acc_word   <= '0;
      end else begin
         rej_valid  <= rej_pass;
         rej_src    <= rej_pass ? raw_rej_src : '0;
         rsnd_valid <= raw_rsnd;
         acc_valid  <= acc_fire;
         acc_word   <= acc_fire ? {cur_prio, pend_src} : '0;
      end
   end
endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
   import irqp_pkg::*;
#(
   parameter int PRIO_W  = 8,
   parameter int SRC_W   = 24,
   parameter int IPI_SRC = 2,
   localparam int WORD_W = PRIO_W + SRC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [WORD_W-1:0] cmd_data,
   input  logic              eoi_asserted,
   output logic              irq_req,
   output logic              acc_valid,
   output logic [WORD_W-1:0] acc_word,
   output logic              rej_valid,
   output logic [SRC_W-1:0]  rej_src,
   output logic              rsnd_valid
);
   localparam logic [PRIO_W-1:0] NONE_PRIO = '1;
   localparam logic [SRC_W-1:0]  IPI_ID    = SRC_W'(IPI_SRC);

   generate
      if (IPI_SRC <= 0 || IPI_SRC >= (2 ** SRC_W)) begin : g_bad_ipi
         $error("IPI_SRC must be nonzero and fit in SRC_W bits");
      end
      if (PRIO_W < 2 || SRC_W < 2) begin : g_bad_width
         $error("PRIO_W and SRC_W must be at least 2");
      end
   endgenerate

   irqp_op_e          op;
   logic [PRIO_W-1:0] cur_q, ipi_q, pend_q;
   logic [SRC_W-1:0]  src_q;
   logic              need_q;
   logic [PRIO_W-1:0] cur_d, ipi_d, pend_d;
   logic [SRC_W-1:0]  src_d;
   logic              need_d;
   logic              raw_rej, raw_rsnd, acc_fire;
   logic [SRC_W-1:0]  raw_rej_src;

   assign op = irqp_op_e'(cmd_op);

   irqp_next #(.PRIO_W(PRIO_W), .SRC_W(SRC_W), .IPI_SRC(IPI_SRC)) u_next (
      .fire        (cmd_valid),
      .op          (op),
      .data        (cmd_data),
      .eoi_asserted(eoi_asserted),
      .cur_prio    (cur_q),
      .ipi_prio    (ipi_q),
      .pend_prio   (pend_q),
      .pend_src    (src_q),
      .need_rsnd   (need_q),
      .n_cur_prio  (cur_d),
      .n_ipi_prio  (ipi_d),
      .n_pend_prio (pend_d),
      .n_pend_src  (src_d),
      .n_need_rsnd (need_d),
      .raw_rej     (raw_rej),
      .raw_rej_src (raw_rej_src),
      .raw_rsnd    (raw_rsnd),
      .acc_fire    (acc_fire)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q  <= '0;
         ipi_q  <= NONE_PRIO;
         pend_q <= NONE_PRIO;
         src_q  <= '0;
         need_q <= 1'b0;
      end else begin
         cur_q  <= cur_d;
         ipi_q  <= ipi_d;
         pend_q <= pend_d;
         src_q  <= src_d;
         need_q <= need_d;
      end
   end

   irqp_notify #(.PRIO_W(PRIO_W), .SRC_W(SRC_W), .IPI_SRC(IPI_SRC)) u_notify (
      .clk        (clk),
      .rst_n      (rst_n),
      .raw_rej    (raw_rej),
      .raw_rej_src(raw_rej_src),
      .raw_rsnd   (raw_rsnd),
      .acc_fire   (acc_fire),
      .cur_prio   (cur_q),
      .pend_src   (src_q),
      .rej_valid  (rej_valid),
      .rej_src    (rej_src),
      .rsnd_valid (rsnd_valid),
      .acc_valid  (acc_valid),
      .acc_word   (acc_word)
   );

   assign irq_req = (src_q != '0) && (pend_q < cur_q);

   AST_SRC_PEND_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (src_q != '0) == (pend_q != NONE_PRIO)); // R11

   AST_ACC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && op == OP_ACCEPT && src_q != '0) |=>
      (acc_valid && src_q == '0 && pend_q == NONE_PRIO)); // R3

   AST_CPPR_EQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && op == OP_SET_CPPR && cmd_data[PRIO_W-1:0] == cur_q) |=>
      ($stable(cur_q) && $stable(src_q) && $stable(pend_q) && !rej_valid && !rsnd_valid)); // R6

   AST_REJ_FILTERED: assert property (@(posedge clk) disable iff (!rst_n)
      rej_valid |-> (rej_src != '0 && rej_src != IPI_ID)); // R10

   AST_RESEND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      rsnd_valid |-> !need_q); // R5

   AST_IPI_STORED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && op == OP_SET_IPI) |=> (ipi_q == $past(cmd_data[PRIO_W-1:0]))); // R4
endmodule

// File: tb/irq_presenter_bench.sv
module irq_presenter_bench;
   typedef struct packed {
      logic [2:0]  op;
      logic [31:0] data;
      logic        ast;
      logic        irq;
      logic        rv;
      logic [23:0] rs;
      logic        rsnd;
      logic [31:0] acc;
   } vec_t;

   localparam int NV = 21;
   // op codes: 1 accept, 2 set current, 3 set IPI, 4 EOI, 5 deliver
   localparam vec_t VECS [NV] = '{
      '{3'd2, 32'h000000FF, 1'b0, 1'b0, 1'b0, 24'h0,  1'b0, 32'h0},         // R7 relax to FF
      '{3'd5, 32'h05000010, 1'b0, 1'b1, 1'b0, 24'h0,  1'b0, 32'h0},         // R11 R2 taken
      '{3'd5, 32'h07000011, 1'b0, 1'b1, 1'b1, 24'h11, 1'b0, 32'h0},         // R11 refused
      '{3'd5, 32'h03000012, 1'b0, 1'b1, 1'b1, 24'h10, 1'b0, 32'h0},         // R11 displaces
      '{3'd1, 32'h0,        1'b0, 1'b0, 1'b0, 24'h0,  1'b0, 32'hFF000012},  // R3 accept
      '{3'd3, 32'h00000001, 1'b0, 1'b1, 1'b0, 24'h0,  1'b0, 32'h0},         // R4 R10 IPI pending
      '{3'd2, 32'h00000001, 1'b0, 1'b0, 1'b0, 24'h0,  1'b0, 32'h0},         // R8 R10 IPI dropped
      '{3'd2, 32'h00000001, 1'b0, 1'b0, 1'b0, 24'h0,  1'b0, 32'h0},         // R6 equal
      '{3'd3, 32'h00000040, 1'b0, 1'b0, 1'b0, 24'h0,  1'b1, 32'h0},         // R5 resend
      '{3'd4, 32'h80000012, 1'b1, 1'b1, 1'b1, 24'h12, 1'b0, 32'h0},         // R9 R7 asserted
      '{3'd1, 32'h0,        1'b0, 1'b0, 1'b0, 24'h0,  1'b0, 32'h80000002},  // R3 accept IPI
      '{3'd4, 32'hFF000002, 1'b1, 1'b1, 1'b0, 24'h0,  1'b0, 32'h0},         // R9 R10 IPI EOI
      '{3'd5, 32'h50000020, 1'b0, 1'b1, 1'b1, 24'h20, 1'b0, 32'h0},         // R11 refused
      '{3'd4, 32'hFF000030, 1'b0, 1'b1, 1'b0, 24'h0,  1'b1, 32'h0},         // R9 R5 deasserted
      '{3'd5, 32'h10000021, 1'b0, 1'b1, 1'b0, 24'h0,  1'b0, 32'h0},         // R11 R10 over IPI
      '{3'd2, 32'h00000010, 1'b0, 1'b0, 1'b1, 24'h21, 1'b0, 32'h0},         // R8 reject
      '{3'd1, 32'h0,        1'b0, 1'b0, 1'b0, 24'h0,  1'b0, 32'h10000000},  // R3 empty accept
      '{3'd7, 32'h000000FF, 1'b0, 1'b0, 1'b0, 24'h0,  1'b0, 32'h0},         // R12 undefined op
      '{3'd1, 32'h0,        1'b0, 1'b0, 1'b0, 24'h0,  1'b0, 32'h10000000},  // R12 state kept
      '{3'd5, 32'h05000000, 1'b0, 1'b0, 1'b0, 24'h0,  1'b0, 32'h0},         // R11 source 0
      '{3'd3, 32'h000000FF, 1'b0, 1'b0, 1'b0, 24'h0,  1'b0, 32'h0}          // R11 no resend owed
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_op = 3'd0;
   logic [31:0] cmd_data = 32'h0;
   logic        eoi_asserted = 1'b0;
   logic        irq_req, acc_valid, rej_valid, rsnd_valid;
   logic [31:0] acc_word;
   logic [23:0] rej_src;
   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   irq_presenter u_irq_presenter (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_data(cmd_data), .eoi_asserted(eoi_asserted), .irq_req(irq_req),
      .acc_valid(acc_valid), .acc_word(acc_word), .rej_valid(rej_valid),
      .rej_src(rej_src), .rsnd_valid(rsnd_valid)
   );

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", what, act, exp);
      end
   endtask

   task automatic issue(input logic [2:0] op, input logic [31:0] d, input logic a);
      cmd_valid    = 1'b1;
      cmd_op       = op;
      cmd_data     = d;
      eoi_asserted = a;
      @(posedge clk);
      @(negedge clk);
      cmd_valid    = 1'b0;
      cmd_op       = 3'd0;
      eoi_asserted = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      do_reset();
      chk("R1 irq after reset", {31'h0, irq_req}, 32'h0);
      chk("R1 pulses after reset", {29'h0, rej_valid, rsnd_valid, acc_valid}, 32'h0);
      issue(3'd1, 32'h0, 1'b0);
      chk("R1 R3 accept valid", {31'h0, acc_valid}, 32'h1);
      chk("R1 accept word", acc_word, 32'h0);
      issue(3'd5, 32'h07000011, 1'b0);
      chk("R11 refuse at prio 0", {7'h0, rej_valid, rej_src}, {8'h01, 24'h11});
      @(negedge clk);
      chk("R12 reject is one cycle", {31'h0, rej_valid}, 32'h0);
      chk("R12 accept is one cycle", {31'h0, acc_valid}, 32'h0);
      issue(3'd2, 32'h000000FF, 1'b0);
      chk("R7 resend owed after refusal", {31'h0, rsnd_valid}, 32'h1);

      do_reset();
      for (int i = 0; i < NV; i++) begin
         issue(VECS[i].op, VECS[i].data, VECS[i].ast);
         chk($sformatf("table step %0d irq_req", i), {31'h0, irq_req}, {31'h0, VECS[i].irq});
         chk($sformatf("table step %0d rej_valid", i), {31'h0, rej_valid}, {31'h0, VECS[i].rv});
         if (VECS[i].rv)
            chk($sformatf("table step %0d rej_src", i), {8'h0, rej_src}, {8'h0, VECS[i].rs});
         chk($sformatf("table step %0d rsnd_valid", i), {31'h0, rsnd_valid}, {31'h0, VECS[i].rsnd});
         chk($sformatf("table step %0d acc_valid", i), {31'h0, acc_valid},
             {31'h0, (VECS[i].op == 3'd1)});
         if (VECS[i].op == 3'd1)
            chk($sformatf("table step %0d acc_word", i), acc_word, VECS[i].acc);
      end

      issue(3'd3, 32'h00000001, 1'b0);
      do_reset();
      chk("R1 irq after mid-run reset", {31'h0, irq_req}, 32'h0);
      issue(3'd1, 32'h0, 1'b0);
      chk("R1 accept word after mid-run reset", acc_word, 32'h0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule